// File: doc/BRIEF.md
# Hardware Interrupt Line Mapper

The mapper takes a bank of external interrupt request lines and turns them into a single stream of interrupt vectors. Each line owns a programmable map entry that holds an 8-bit vector and a 3-bit trigger mode. Five trigger behaviours can be selected per line: off, rising edge, falling edge, active-high level and active-low level. Every line passes through a two-flop synchronizer before it is detected. A request is then held per line until it is served.

The highest-priority request is presented as one vector, together with its line number, on a valid/ready output. The lowest line index wins. Once a vector is presented it stays unchanged until the consumer accepts it.

A small register port programs and reads back the map entries. The same port also takes end-of-interrupt writes. A level-triggered line is not presented again until its end-of-interrupt write arrives. Edge-triggered lines re-arm on their next edge.

Top module: `irq_line_mapper`

## Requirements
- R1: After reset, irq_valid is 0 and every map entry reads back as zero.
- R2: reg_addr bit 4 selects the bank: 0 selects the map entry of line reg_addr[3:0], and 1 selects that line's end-of-interrupt register. A map entry holds the vector in data bits [7:0] and the mode in bits [10:8]. A read returns the entry on reg_rdata the cycle after reg_rd. All other bits read as zero, and a read of the end-of-interrupt bank returns zero.
- R3: The mode codes are 0 off, 1 rising edge, 2 falling edge, 5 level active-high and 6 level active-low. The codes 3, 4 and 7 are stored as written but behave like off.
- R4: In rising-edge mode, a 0-to-1 change on the line presents that line's vector on the 4th rising clock edge after the change, with irq_valid=1 and irq_line set to the line number.
- R5: In falling-edge mode, a 1-to-0 change presents the vector with the same four-edge latency.
- R6: When several lines request at once, the lowest-numbered line is presented first. A presented vector and line number stay stable while irq_ready is 0, even if a higher-priority line starts requesting.
- R7: A clock edge with irq_valid and irq_ready both high accepts the vector. irq_valid is 0 after that edge, and the next pending line is presented one edge later.
- R8: An edge-mode line needs no end-of-interrupt write. A new edge after acceptance presents it again.
- R9: A level-mode line is presented 3 edges after it becomes active. After acceptance it is not presented again until its end-of-interrupt write. After that write it is presented on the next edge only if its level is still active.
- R10: In active-low level mode, a low line is the active state and a high line is idle.
- R11: An off line never requests. Writing a line's map entry clears its pending and in-service state. If that line is being presented, irq_valid drops at the edge of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Asynchronous interrupt request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Bit 4 bank select, bits [3:0] line |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq_valid | output | 1 | A vector is presented |
| irq_ready | input | 1 | Consumer accepts the presented vector |
| irq_vector | output | 8 | Presented vector |
| irq_line | output | 4 | Line number of the presented vector |

## Verification
The assertions assume that software writes zero to every reserved bit of a map entry, and one property checks exactly that at the register port. The bench only ever writes values that fit the vector and mode fields.

The assertions also assume that reg_wr and reg_rd are never asserted together. The bench drives each access from its own task, one at a time.

Stimulus changes the request lines and the handshake only just after a falling clock edge, so every line is held for whole cycles before the synchronizer samples it. When a line is switched to active-low, the bench first raises the line and lets it settle, so that it does not start out asserted.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_OFF  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_RISE = 3'd1;
  localparam logic [MODE_W-1:0] MODE_FALL = 3'd2;
  localparam logic [MODE_W-1:0] MODE_HIGH = 3'd5;
  localparam logic [MODE_W-1:0] MODE_LOW  = 3'd6;

  function automatic logic mode_is_edge(input logic [MODE_W-1:0] m);
    return (m == MODE_RISE) || (m == MODE_FALL);
  endfunction

  function automatic logic mode_is_level(input logic [MODE_W-1:0] m);
    return (m == MODE_HIGH) || (m == MODE_LOW);
  endfunction

  function automatic logic mode_is_live(input logic [MODE_W-1:0] m);
    return mode_is_edge(m) || mode_is_level(m);
  endfunction
endpackage

// File: rtl/irqm_sync.sv
module irqm_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/irqm_line.sv
module irqm_line
  import irqm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lvl,
  input  logic [MODE_W-1:0] mode,
  input  logic              clr,
  input  logic              acc,
  input  logic              eoi,
  output logic              req
);
  logic prev_q, edge_pend_q, in_svc_q;
  logic edge_hit, level_on;

  assign edge_hit = ((mode == MODE_RISE) && lvl && !prev_q) ||
                    ((mode == MODE_FALL) && !lvl && prev_q);
  assign level_on = ((mode == MODE_HIGH) && lvl) ||
                    ((mode == MODE_LOW) && !lvl);

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)    edge_pend_q <= 1'b0;
    else if (edge_hit) edge_pend_q <= 1'b1;
    else if (acc)      edge_pend_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)                        in_svc_q <= 1'b0;
    else if (acc && mode_is_level(mode))   in_svc_q <= 1'b1;
    else if (eoi)                          in_svc_q <= 1'b0;
  end

  assign req = edge_pend_q || (level_on && !in_svc_q);

  // R11: a line whose mode is off or unsupported never requests
  p_off_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !mode_is_live(mode) |-> !req);

  // R9: an in-service level line stays silent until end of interrupt
  p_svc_gate_r9: assert property (@(posedge clk) disable iff (rst)
    in_svc_q |-> !req);

  // R7: accepting an edge request without a fresh edge retires it
  p_edge_retire_r7: assert property (@(posedge clk) disable iff (rst)
    (acc && mode_is_edge(mode) && !edge_hit && !clr) |=> !req);
endmodule

// File: rtl/irqm_prio.sv
module irqm_prio #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any   = |req;
  assign grant = any ? (N'(1) << idx) : '0;

  // R6: at most one line granted
  p_one_grant_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  generate
    for (genvar g = 1; g < N; g++) begin : g_chk
      localparam logic [N-1:0] LOWER = (N'(1) << g) - N'(1);
      // R6: a grant implies no lower-numbered line is requesting
      p_low_first_r6: assert property (@(posedge clk) disable iff (rst)
        grant[g] |-> ((req & LOWER) == '0));
    end
  endgenerate
endmodule

// File: rtl/irq_line_mapper.sv
module irq_line_mapper
  import irqm_pkg::*;
#(
  parameter int NUM_LINES   = 16,
  parameter int VEC_W       = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int LINE_W     = $clog2(NUM_LINES),
  localparam int ADDR_W     = LINE_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 irq_valid,
  input  logic                 irq_ready,
  output logic [VEC_W-1:0]     irq_vector,
  output logic [LINE_W-1:0]    irq_line
);
  localparam int ENTRY_W = VEC_W + MODE_W;

  logic [VEC_W-1:0]     vec_q  [NUM_LINES];
  logic [MODE_W-1:0]    mode_q [NUM_LINES];
  logic [NUM_LINES-1:0] lvl_s, req, grant;
  logic [LINE_W-1:0]    win_idx, sel;
  logic                 win_any, wr_map, wr_eoi, withdraw, accept, load_ok;

  assign sel    = reg_addr[LINE_W-1:0];
  assign wr_map = reg_wr && !reg_addr[ADDR_W-1];
  assign wr_eoi = reg_wr &&  reg_addr[ADDR_W-1];

  // Map entry storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        vec_q[i]  <= '0;
        mode_q[i] <= MODE_OFF;
      end
    end else if (wr_map) begin
      vec_q[sel]  <= reg_wdata[VEC_W-1:0];
      mode_q[sel] <= reg_wdata[ENTRY_W-1:VEC_W];
    end
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      if (reg_rd && !reg_addr[ADDR_W-1])
        reg_rdata <= DATA_W'({mode_q[sel], vec_q[sel]});
    end
  end

  irqm_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (irq_in),
    .dout(lvl_s)
  );

  assign accept = irq_valid && irq_ready;

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      irqm_line u_line (
        .clk (clk),
        .rst (rst),
        .lvl (lvl_s[g]),
        .mode(mode_q[g]),
        .clr (wr_map && (sel == LINE_W'(g))),
        .acc (accept && (irq_line == LINE_W'(g))),
        .eoi (wr_eoi && (sel == LINE_W'(g))),
        .req (req[g])
      );
    end
  endgenerate

  irqm_prio #(.N(NUM_LINES)) u_prio (
    .clk  (clk),
    .rst  (rst),
    .req  (req),
    .grant(grant),
    .idx  (win_idx),
    .any  (win_any)
  );

  assign withdraw = irq_valid && wr_map && (sel == irq_line);
  assign load_ok  = win_any && !(wr_map && (sel == win_idx));

  // Presentation register
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
      irq_line   <= '0;
    end else if (irq_valid) begin
      if (irq_ready || withdraw) irq_valid <= 1'b0;
    end else if (load_ok) begin
      irq_valid  <= 1'b1;
      irq_vector <= vec_q[win_idx];
      irq_line   <= win_idx;
    end
  end

  // R6: an unaccepted vector holds still unless its entry is rewritten
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !irq_ready && !withdraw) |=>
      (irq_valid && $stable(irq_vector) && $stable(irq_line)));

  // R7: acceptance drops valid for one cycle
  p_accept_drop_r7: assert property (@(posedge clk) disable iff (rst)
    accept |=> !irq_valid);

  // R11: rewriting the presented entry withdraws it
  p_withdraw_r11: assert property (@(posedge clk) disable iff (rst)
    withdraw |=> !irq_valid);

  // R2: reserved read bits are zero and writes keep reserved bits clear
  p_rsvd_rd_r2: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DATA_W-1:ENTRY_W] == '0);
  p_rsvd_wr_r2: assert property (@(posedge clk) disable iff (rst)
    wr_map |-> (reg_wdata[DATA_W-1:ENTRY_W] == '0));
  p_one_access_r2: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));
endmodule

// File: tb/irq_line_mapper_bench.sv
`timescale 1ns/1ps
module irq_line_mapper_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_in = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, irq_ready = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_valid;
  logic [7:0]  irq_vector;
  logic [3:0]  irq_line;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_line_mapper u_irq_line_mapper (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_vector(irq_vector), .irq_line(irq_line)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    step(1);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic take();
    irq_ready = 1'b1;
    step(1);
    irq_ready = 1'b0;
  endtask

  task automatic chk_vec(input string tag, input logic [7:0] v, input logic [3:0] l);
    chk({tag, " valid"}, 32'(irq_valid), 32'd1);
    chk({tag, " vector"}, 32'(irq_vector), 32'(v));
    chk({tag, " line"}, 32'(irq_line), 32'(l));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 valid after reset", 32'(irq_valid), 32'd0);
    rd(5'd0, d);  chk("R1 entry 0", d, 32'd0);
    rd(5'd15, d); chk("R1 entry 15", d, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(5'd0, 32'h7A5);
    rd(5'd0, d);  chk("R2 readback", d, 32'h7A5);
    rd(5'd16, d); chk("R2 eoi bank reads zero", d, 32'd0);
    wr(5'd0, 32'h0);
    rd(5'd0, d);  chk("R2 cleared", d, 32'd0);
  endtask

  task automatic t_rise();
    wr(5'd2, 32'h142);
    irq_in[2] = 1'b1;
    step(3); chk("R4 not before 4th edge", 32'(irq_valid), 32'd0);
    step(1); chk_vec("R4 rising", 8'h42, 4'd2);
    take();  chk("R7 drop after accept", 32'(irq_valid), 32'd0);
    step(4); chk("R4 no repeat while high", 32'(irq_valid), 32'd0);
    wr(5'd2, 32'h0);
    irq_in[2] = 1'b0;
    step(3);
  endtask

  task automatic t_fall();
    irq_in[11] = 1'b1;
    step(3);
    wr(5'd11, 32'h2B1);
    step(3); chk("R5 idle while high", 32'(irq_valid), 32'd0);
    irq_in[11] = 1'b0;
    step(3); chk("R5 not before 4th edge", 32'(irq_valid), 32'd0);
    step(1); chk_vec("R5 falling", 8'hB1, 4'd11);
    take();
    wr(5'd11, 32'h0);
    step(2);
  endtask

  task automatic t_prio();
    wr(5'd3, 32'h133);
    wr(5'd9, 32'h199);
    wr(5'd1, 32'h111);
    irq_in[3] = 1'b1; irq_in[9] = 1'b1;
    step(4); chk_vec("R6 lowest first", 8'h33, 4'd3);
    irq_in[1] = 1'b1;
    step(5); chk_vec("R6 held while not ready", 8'h33, 4'd3);
    take();  chk("R7 gap after accept", 32'(irq_valid), 32'd0);
    step(1); chk_vec("R7 next pending", 8'h11, 4'd1);
    take();
    step(1); chk_vec("R6 last pending", 8'h99, 4'd9);
    take();
    step(3); chk("R7 all served", 32'(irq_valid), 32'd0);
  endtask

  task automatic t_rearm();
    irq_in[3] = 1'b0;
    step(3);
    irq_in[3] = 1'b1;
    step(4); chk_vec("R8 new edge without eoi", 8'h33, 4'd3);
    take();
    wr(5'd1, 32'h0); wr(5'd3, 32'h0); wr(5'd9, 32'h0);
    irq_in[1] = 1'b0; irq_in[3] = 1'b0; irq_in[9] = 1'b0;
    step(3);
  endtask

  task automatic t_level_high();
    wr(5'd5, 32'h555);
    irq_in[5] = 1'b1;
    step(2); chk("R9 not before 3rd edge", 32'(irq_valid), 32'd0);
    step(1); chk_vec("R9 level high", 8'h55, 4'd5);
    take();
    step(4); chk("R9 silent until eoi", 32'(irq_valid), 32'd0);
    wr(5'd21, 32'h0);
    chk("R9 eoi edge itself", 32'(irq_valid), 32'd0);
    step(1); chk_vec("R9 re-presented after eoi", 8'h55, 4'd5);
    take();
    irq_in[5] = 1'b0;
    step(3);
    wr(5'd21, 32'h0);
    step(3); chk("R9 no repeat when inactive", 32'(irq_valid), 32'd0);
    wr(5'd5, 32'h0);
  endtask

  task automatic t_level_low();
    irq_in[6] = 1'b1;
    step(3);
    wr(5'd6, 32'h666);
    step(3); chk("R10 high is idle", 32'(irq_valid), 32'd0);
    irq_in[6] = 1'b0;
    step(2); chk("R10 not before 3rd edge", 32'(irq_valid), 32'd0);
    step(1); chk_vec("R10 low active", 8'h66, 4'd6);
    take();
    irq_in[6] = 1'b1;
    step(3);
    wr(5'd22, 32'h0);
    step(3); chk("R10 released", 32'(irq_valid), 32'd0);
    wr(5'd6, 32'h0);
    irq_in[6] = 1'b0;
    step(3);
  endtask

  task automatic t_off();
    logic [31:0] d;
    wr(5'd4, 32'h344);
    irq_in[4] = 1'b1;
    step(6); chk("R3 code 3 acts off", 32'(irq_valid), 32'd0);
    irq_in[4] = 1'b0;
    step(6); chk("R3 code 3 no fall", 32'(irq_valid), 32'd0);
    rd(5'd4, d); chk("R3 code stored", d, 32'h344);
    wr(5'd4, 32'h0);
    wr(5'd7, 32'h177);
    irq_in[7] = 1'b1;
    step(4); chk_vec("R11 setup", 8'h77, 4'd7);
    wr(5'd7, 32'h0);
    chk("R11 withdraw on write", 32'(irq_valid), 32'd0);
    step(5); chk("R11 stays cleared", 32'(irq_valid), 32'd0);
    irq_in[7] = 1'b0;
    step(3);
    irq_in[7] = 1'b1;
    step(6); chk("R11 off line ignores edges", 32'(irq_valid), 32'd0);
    irq_in[7] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_regs();
    t_rise();
    t_fall();
    t_prio();
    t_rearm();
    t_level_high();
    t_level_low();
    t_off();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule